// File: doc/BRIEF.md
# Refresh-Aware Burst Splitter

This block sits between a host that issues long linear read or write bursts and a self-refreshing pseudo-static memory. That memory refreshes its array on its own between transactions. It can only do so if chip select goes high often enough. The host asks for one burst of any length. The block cuts the burst into pieces, and each piece keeps chip select low for fewer cycles than the current limit. Between pieces chip select stays high for a set number of cycles, and the next piece starts at the following address with the beats that remain.

The limit is either 4 µs or 1 µs, converted to clock cycles from the clock-frequency parameter. In code mode a 2-bit refresh-interval code selects it. In temperature mode a junction-temperature reading in °C selects it. The size of each piece is fixed in advance. It leaves room for the command phase, a doubled initial latency and the cycle in which chip select rises, so the limit is never reached whatever the memory reports.

When the memory raises its latency-extension flag during the command phase, the block waits twice the normal initial latency before the first beat. The host sees one continuous burst. Its per-beat strobe simply pauses across the piece boundaries, and a single done pulse follows the final beat.

The request channel is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a new request waits until the previous burst has ended. The beat channel has no back-pressure. The host must supply write data, and accept read data, on every cycle that `host_beat` is high.

Top module: `bsplit_top`

## Requirements
- R1: `req_ready` is high only while no burst is in progress. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` is low in the following cycle for any nonzero length.
- R2: In code mode (`temp_mode`=0), code 2'b01 selects the 4 µs limit (4·CLK_MHZ cycles) and code 2'b10 selects the 1 µs limit (CLK_MHZ cycles). Codes 2'b00 and 2'b11 also select the 1 µs limit.
- R3: In temperature mode (`temp_mode`=1), the code is ignored. `temp_c` ≥ 85 selects the 1 µs limit and `temp_c` < 85 selects the 4 µs limit.
- R4: Each piece carries min(remaining beats, LIMIT − CMD_CYC − 2·LAT_CYC − 1) beats, which gives 84 or 384 beats at the default parameters. `mem_len` shows this count during the command pulse. Chip select is low for exactly CMD_CYC + latency + beats cycles, and this is always fewer than the limit.
- R5: Each piece begins with a one-cycle `mem_cmd` pulse, which is the first cycle of chip-select activity. `mem_addr` is the start address plus the beats already transferred, and `mem_write` keeps the direction of the request. The number of pieces is the smallest that covers the length.
- R6: The first beat of a piece comes CMD_CYC + LAT_CYC cycles after its command pulse. If `mem_lat_ext` is high during any command-phase cycle, the first beat comes CMD_CYC + 2·LAT_CYC cycles after it instead.
- R7: Between two pieces of one burst, chip select stays inactive for exactly max(`gap_cyc`, 1) cycles.
- R8: `host_beat` is high on exactly the cycles of memory beats, and the burst has `req_len` of them in total. Write data is passed to `mem_wdata` in address order, and read data is passed from `mem_rdata` in address order.
- R9: `done` is a one-cycle pulse, issued once per burst, in the cycle after the final beat. A request with length 0 produces `done` in the cycle after it is taken, with no chip-select activity.
- R10: After reset, `req_ready`=1, `mem_cs`=0, `mem_cmd`=0, `host_beat`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host burst request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Burst start address (in beats) |
| req_len | input | LEN_W | Burst length in beats |
| req_write | input | 1 | 1 = write, 0 = read |
| host_beat | output | 1 | Beat strobe toward the host |
| host_wdata | input | DATA_W | Write data for the current beat |
| host_rdata | output | DATA_W | Read data for the current beat |
| done | output | 1 | Pulse after the final beat of a burst |
| ref_code | input | 2 | Refresh-interval code |
| temp_mode | input | 1 | 1 = select the limit from temperature |
| temp_c | input | TEMP_W | Junction temperature in °C |
| gap_cyc | input | GAP_W | Minimum chip-select-high cycles between pieces |
| mem_cs | output | 1 | Chip select active (1 = selected) |
| mem_cmd | output | 1 | Command pulse of a piece |
| mem_addr | output | ADDR_W | Piece start address (valid with mem_cmd) |
| mem_len | output | LEN_W | Piece length (valid with mem_cmd) |
| mem_write | output | 1 | Piece direction |
| mem_lat_ext | input | 1 | Memory requests doubled latency |
| mem_beat | output | 1 | Memory data beat |
| mem_wdata | output | DATA_W | Write data to the memory |
| mem_rdata | input | DATA_W | Read data from the memory |

## Verification
Bursts are run that fit in one piece, that fill a piece exactly, that exceed a piece by a single beat, and that need several pieces. These show whether the piece boundary and the continuation address are computed correctly. Every code value is tried, and temperatures just below 85, at 85 and at 125, with the code set opposite to the temperature's choice. This separates a wrong fallback from a temperature mode that still reads the code. The latency flag is raised on chosen pieces, and the gap setting is varied, including zero. These patterns show whether the wait is doubled only where the flag was seen and whether zero is raised to one. Reads and writes carry address-derived data, so that dropped, repeated or reordered beats across a split are caught, and a zero-length request covers the empty case.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_LAT, S_DATA, S_GAP} seq_state_t;
  localparam logic [1:0] CODE_LONG = 2'b01;
  localparam int         HOT_C     = 85;
endpackage

// File: rtl/bsplit_limit.sv
module bsplit_limit
  import bsplit_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int CMD_CYC = 3,
  parameter int LAT_CYC = 6,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 10,
  parameter int TEMP_W  = 8
) (
  input  logic [1:0]        ref_code,
  input  logic              temp_mode,
  input  logic [TEMP_W-1:0] temp_c,
  output logic [LEN_W-1:0]  max_beats,
  output logic [CNT_W-1:0]  lim_cyc
);
  localparam int CYC_SHORT   = CLK_MHZ;
  localparam int CYC_LONG    = 4 * CLK_MHZ;
  localparam int MARGIN      = CMD_CYC + 2 * LAT_CYC + 1;
  localparam int BEATS_SHORT = CYC_SHORT - MARGIN;
  localparam int BEATS_LONG  = CYC_LONG - MARGIN;

  logic use_short;

  always_comb begin
    if (temp_mode) use_short = (temp_c >= TEMP_W'(HOT_C));
    else           use_short = (ref_code != CODE_LONG);
  end

  assign max_beats = use_short ? LEN_W'(BEATS_SHORT) : LEN_W'(BEATS_LONG);
  assign lim_cyc   = use_short ? CNT_W'(CYC_SHORT)   : CNT_W'(CYC_LONG);

  // R2: a code other than the long one gives the short piece size
  always_comb begin
    if (!temp_mode && ref_code != CODE_LONG)
      p_code_fallback_r2: assert (max_beats < LEN_W'(BEATS_LONG));
  end

  // R3: below the threshold the long piece size applies, whatever the code
  always_comb begin
    if (temp_mode && temp_c < TEMP_W'(HOT_C))
      p_temp_cool_r3: assert (lim_cyc == CNT_W'(CYC_LONG));
  end
endmodule

// File: rtl/bsplit_track.sv
module bsplit_track #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ld_write,
  input  logic              beat,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remaining,
  output logic              write_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
      write_q   <= 1'b0;
    end else if (load) begin
      cur_addr  <= ld_addr;
      remaining <= ld_len;
      write_q   <= ld_write;
    end else if (beat) begin
      cur_addr  <= cur_addr + ADDR_W'(1);
      remaining <= remaining - LEN_W'(1);
    end
  end

  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> remaining != '0);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> cur_addr == $past(cur_addr) + ADDR_W'(1));
endmodule

// File: rtl/bsplit_seq.sv
module bsplit_seq
  import bsplit_pkg::*;
#(
  parameter int CMD_CYC = 3,
  parameter int LAT_CYC = 6,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 10,
  parameter int GAP_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [LEN_W-1:0] remaining,
  input  logic [LEN_W-1:0] max_beats,
  input  logic [CNT_W-1:0] lim_cyc,
  input  logic             lat_ext,
  input  logic [GAP_W-1:0] gap_cyc,
  output logic             req_ready,
  output logic             load,
  output logic             mem_cs,
  output logic             mem_cmd,
  output logic [LEN_W-1:0] piece_len,
  output logic             beat,
  output logic             done
);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_CYC - 1);
  localparam logic [CNT_W-1:0] LAT_ONE  = CNT_W'(LAT_CYC);
  localparam logic [CNT_W-1:0] LAT_TWO  = CNT_W'(2 * LAT_CYC);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [GAP_W-1:0] gcnt;
  logic [LEN_W-1:0] pcnt;
  logic [CNT_W-1:0] lim_q;
  logic             lat_q;
  logic [CNT_W-1:0] lat_len;
  logic [GAP_W-1:0] gap_eff;

  assign piece_len = (remaining < max_beats) ? remaining : max_beats;
  assign lat_len   = lat_q ? LAT_TWO : LAT_ONE;
  assign gap_eff   = (gap_cyc == '0) ? GAP_W'(1) : gap_cyc;

  assign req_ready = (state == S_IDLE);
  assign load      = req_ready && req_valid;
  assign mem_cs    = (state == S_CMD) || (state == S_LAT) || (state == S_DATA);
  assign mem_cmd   = (state == S_CMD) && (cnt == '0);
  assign beat      = (state == S_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      gcnt  <= '0;
      pcnt  <= '0;
      lim_q <= '0;
      lat_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_len == '0) begin
              done <= 1'b1;
            end else begin
              state <= S_CMD;
              cnt   <= '0;
            end
          end
        end
        S_CMD: begin
          if (cnt == '0) begin
            lat_q <= lat_ext;
            pcnt  <= piece_len;
            lim_q <= lim_cyc;
          end else begin
            lat_q <= lat_q | lat_ext;
          end
          if (cnt == CMD_LAST) begin
            state <= S_LAT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_LAT: begin
          if (cnt == lat_len - CNT_W'(1)) begin
            state <= S_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_DATA: begin
          pcnt <= pcnt - LEN_W'(1);
          if (pcnt == LEN_W'(1)) begin
            if (remaining == LEN_W'(1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              state <= S_GAP;
              gcnt  <= '0;
            end
          end
        end
        S_GAP: begin
          if (gcnt == gap_eff - GAP_W'(1)) begin
            state <= S_CMD;
            cnt   <= '0;
          end else begin
            gcnt <= gcnt + GAP_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Observation counters for the timing properties below
  logic [CNT_W-1:0] cs_run;
  logic [CNT_W-1:0] since_cmd;
  logic [GAP_W:0]   gap_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_run    <= '0;
      since_cmd <= '0;
      gap_run   <= '0;
    end else begin
      if (!mem_cs) cs_run <= '0;
      else if (cs_run != '1) cs_run <= cs_run + CNT_W'(1);
      if (mem_cmd) since_cmd <= CNT_W'(1);
      else if (since_cmd != '1) since_cmd <= since_cmd + CNT_W'(1);
      if (mem_cs) gap_run <= '0;
      else if (gap_run != '1) gap_run <= gap_run + (GAP_W+1)'(1);
    end
  end

  p_cs_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && !mem_cmd) |-> cs_run < lim_q);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !$past(beat)) |-> since_cmd == CNT_W'(CMD_CYC) + lat_len);

  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd && $past(state) == S_GAP) |-> gap_run >= {1'b0, gap_eff});

  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(beat) || $past(load)) && !mem_cs);
endmodule

// File: rtl/bsplit_top.sv
module bsplit_top #(
  parameter int CLK_MHZ = 100,
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 16,
  parameter int DATA_W  = 16,
  parameter int CMD_CYC = 3,
  parameter int LAT_CYC = 6,
  parameter int GAP_W   = 8,
  parameter int TEMP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              host_beat,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              done,
  input  logic [1:0]        ref_code,
  input  logic              temp_mode,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [GAP_W-1:0]  gap_cyc,
  output logic              mem_cs,
  output logic              mem_cmd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic              mem_write,
  input  logic              mem_lat_ext,
  output logic              mem_beat,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int CNT_W = $clog2(4 * CLK_MHZ + 1) + 1;

  logic [LEN_W-1:0] max_beats;
  logic [CNT_W-1:0] lim_cyc;
  logic [LEN_W-1:0] remaining;
  logic             load;
  logic             beat;

  bsplit_limit #(
    .CLK_MHZ(CLK_MHZ), .CMD_CYC(CMD_CYC), .LAT_CYC(LAT_CYC),
    .LEN_W(LEN_W), .CNT_W(CNT_W), .TEMP_W(TEMP_W)
  ) u_limit (
    .ref_code (ref_code),
    .temp_mode(temp_mode),
    .temp_c   (temp_c),
    .max_beats(max_beats),
    .lim_cyc  (lim_cyc)
  );

  bsplit_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ld_addr  (req_addr),
    .ld_len   (req_len),
    .ld_write (req_write),
    .beat     (beat),
    .cur_addr (mem_addr),
    .remaining(remaining),
    .write_q  (mem_write)
  );

  bsplit_seq #(
    .CMD_CYC(CMD_CYC), .LAT_CYC(LAT_CYC), .LEN_W(LEN_W),
    .CNT_W(CNT_W), .GAP_W(GAP_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_len  (req_len),
    .remaining(remaining),
    .max_beats(max_beats),
    .lim_cyc  (lim_cyc),
    .lat_ext  (mem_lat_ext),
    .gap_cyc  (gap_cyc),
    .req_ready(req_ready),
    .load     (load),
    .mem_cs   (mem_cs),
    .mem_cmd  (mem_cmd),
    .piece_len(mem_len),
    .beat     (beat),
    .done     (done)
  );

  assign mem_beat   = beat;
  assign host_beat  = beat;
  assign mem_wdata  = host_wdata;
  assign host_rdata = mem_rdata;
endmodule

// File: tb/bsplit_top_tb.sv
module bsplit_top_tb;
  localparam int CMD = 3;
  localparam int LAT = 6;
  localparam int SHORT_LIM = 100;
  localparam int LONG_LIM  = 400;

  typedef struct {
    logic [23:0] a;
    int          n;
    logic        w;
    logic        ext;
    int          idx;
  } piece_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_write = 0;
  logic        host_beat;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        done;
  logic [1:0]  ref_code = 2'b01;
  logic        temp_mode = 0;
  logic [7:0]  temp_c = '0;
  logic [7:0]  gap_cyc = 8'd1;
  logic        mem_cs, mem_cmd, mem_write, mem_beat;
  logic [23:0] mem_addr;
  logic [15:0] mem_len, mem_wdata;
  logic        mem_lat_ext = 0;
  logic [15:0] mem_rdata = '0;

  bsplit_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .host_beat(host_beat), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .done(done), .ref_code(ref_code), .temp_mode(temp_mode), .temp_c(temp_c),
    .gap_cyc(gap_cyc), .mem_cs(mem_cs), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
    .mem_len(mem_len), .mem_write(mem_write), .mem_lat_ext(mem_lat_ext),
    .mem_beat(mem_beat), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  piece_t exp_q[$];

  // burst context shared between driver and monitor
  logic [23:0] b_start;
  int          b_len;
  logic        b_write;
  int          b_gap;
  int          b_lim;
  int          hcnt;
  int          done_cnt;

  function automatic logic [15:0] pat(input logic [23:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  piece_t cur;
  int     since, pbeats, cs_cyc, gap_run;
  logic   prev_cs = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) begin
        hcnt = 0;
        done_cnt = 0;
      end
      if (mem_cmd) begin
        if (exp_q.size() == 0) begin
          check(0, "R5 unexpected command", mem_addr, -1);
        end else begin
          cur = exp_q.pop_front();
          check(mem_addr == cur.a, "R5 piece address", mem_addr, cur.a);
          check(int'(mem_len) == cur.n, "R4 piece length", mem_len, cur.n);
          check(mem_write == cur.w, "R5 piece direction", mem_write, cur.w);
          if (cur.idx > 0) check(gap_run == b_gap, "R7 chip-select gap", gap_run, b_gap);
        end
        mem_lat_ext = cur.ext;
        since = 0;
        pbeats = 0;
        cs_cyc = 1;
      end else if (mem_cs) begin
        since++;
        cs_cyc++;
      end
      if (mem_cs) gap_run = 0;
      else gap_run++;
      if (mem_beat) begin
        if (pbeats == 0)
          check(since == CMD + (cur.ext ? 2*LAT : LAT), "R6 first-beat latency",
                since, CMD + (cur.ext ? 2*LAT : LAT));
        if (cur.w)
          check(mem_wdata == pat(cur.a + 24'(pbeats)), "R8 write data order",
                mem_wdata, pat(cur.a + 24'(pbeats)));
        pbeats++;
      end
      if (host_beat) begin
        if (!b_write)
          check(host_rdata == pat(b_start + 24'(hcnt)), "R8 read data order",
                host_rdata, pat(b_start + 24'(hcnt)));
        hcnt++;
      end
      if (prev_cs && !mem_cs) begin
        check(pbeats == cur.n, "R4 beats in piece", pbeats, cur.n);
        check(cs_cyc == CMD + (cur.ext ? 2*LAT : LAT) + cur.n, "R4 chip-select time",
              cs_cyc, CMD + (cur.ext ? 2*LAT : LAT) + cur.n);
        check(cs_cyc < b_lim, "R4 chip-select under limit", cs_cyc, b_lim);
        mem_lat_ext = 0;
      end
      if (done) begin
        done_cnt++;
        check(hcnt == b_len, "R9 done after final beat", hcnt, b_len);
        check(!mem_cs, "R9 done with chip select idle", mem_cs, 0);
      end
      prev_cs = mem_cs;
      mem_rdata = pat(cur.a + 24'(pbeats));
      host_wdata = pat(b_start + 24'(hcnt));
    end
  end

  // driver: pushes expected pieces, then issues the request
  task automatic run(input logic [23:0] addr, input int len, input logic wr,
                     input logic [1:0] code, input logic tm, input logic [7:0] t,
                     input int gap, input int mask);
    int   maxb, rem, i, wait_n;
    logic sh;
    logic [23:0] a;
    sh = tm ? (t >= 8'd85) : (code != 2'b01);
    maxb = sh ? SHORT_LIM - CMD - 2*LAT - 1 : LONG_LIM - CMD - 2*LAT - 1;
    @(negedge clk);
    ref_code = code; temp_mode = tm; temp_c = t; gap_cyc = 8'(gap);
    b_start = addr; b_len = len; b_write = wr;
    b_gap = (gap == 0) ? 1 : gap;
    b_lim = sh ? SHORT_LIM : LONG_LIM;
    rem = len; a = addr; i = 0;
    while (rem > 0) begin
      piece_t p;
      p.a = a; p.n = (rem < maxb) ? rem : maxb; p.w = wr;
      p.ext = mask[i % 32]; p.idx = i;
      exp_q.push_back(p);
      a = a + 24'(p.n); rem -= p.n; i++;
    end
    check(req_ready == 1'b1, "R1 ready while idle", req_ready, 1);
    req_addr = addr; req_len = 16'(len); req_write = wr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (len > 0) check(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
    wait_n = 0;
    while (done_cnt == 0 && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    check(hcnt == len, "R8 host beat total", hcnt, len);
    check(exp_q.size() == 0, "R5 piece count", exp_q.size(), 0);
    exp_q.delete();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    b_start = '0; b_len = 0; b_write = 0; b_gap = 1; b_lim = LONG_LIM;
    hcnt = 0; done_cnt = 0;
    cur.a = '0; cur.n = 0; cur.w = 0; cur.ext = 0; cur.idx = 0;
    since = 0; pbeats = 0; cs_cyc = 0; gap_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    check(mem_cs == 1'b0, "R10 reset chip select", mem_cs, 0);
    check(mem_cmd == 1'b0, "R10 reset command", mem_cmd, 0);
    check(host_beat == 1'b0, "R10 reset beat", host_beat, 0);
    check(done == 1'b0, "R10 reset done", done, 0);

    run(24'h000100, 10, 1, 2'b01, 0, 8'd0, 2, 0);            // R2 long, single piece
    run(24'h002000, 200, 0, 2'b10, 0, 8'd0, 3, 32'h2);       // R2 short, three pieces, R6
    run(24'h010000, 800, 1, 2'b01, 0, 8'd0, 4, 32'h1);       // R2 long, three pieces
    run(24'h003000, 100, 0, 2'b00, 0, 8'd0, 0, 0);           // R2 fallback, R7 gap zero
    run(24'h004000, 100, 1, 2'b11, 0, 8'd0, 5, 32'h3);       // R2 fallback
    run(24'h005000, 100, 1, 2'b01, 1, 8'd85, 2, 0);          // R3 hot, code ignored
    run(24'h006000, 400, 0, 2'b10, 1, 8'd84, 2, 32'h2);      // R3 cool, code ignored
    run(24'h007000, 90, 0, 2'b01, 1, 8'd125, 1, 0);          // R3 hottest
    run(24'h008000, 84, 1, 2'b10, 0, 8'd0, 2, 0);            // R4 exact fit
    run(24'h009000, 85, 0, 2'b10, 0, 8'd0, 7, 32'h1);        // R4 one beat over
    run(24'h00A000, 0, 1, 2'b10, 0, 8'd0, 2, 0);             // R9 zero length
    check(!mem_cs, "R9 zero length no chip select", mem_cs, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule